// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes stereo PCM audio from a three-wire serial link made of a bit clock, a word-select clock and a data line. It acts only as a clock slave, so both clocks arrive as inputs. The whole block runs on one fast system clock. It finds the bit-clock edges by oversampling the synchronized serial lines. Each received word is two's complement and comes MSB first. The block sign-extends every word to 24 bits and presents a left/right pair on parallel outputs, together with a one-cycle valid pulse once per frame.

A 3-bit format code chooses how the word sits inside each half-frame. The word can be right-aligned against the next word-select edge, left-aligned at the edge, or left-aligned one bit clock after the edge. Right-aligned words are found by keeping a running shift register and capturing its low bits when the next word-select transition arrives. This works for any number of bit clocks per half-frame. The format code is loaded only while the power-down input is high. Power-down also holds the receive logic in its cleared state.

Top module: `audio_rx_slave`

## Requirements
- R1: The format code decodes as 0 = 16-bit right-aligned, 1 = 20-bit right-aligned, 2 = 20-bit left-aligned, 3 = word-select-delayed (I2S-style) 20/16-bit, 4 = 24-bit right-aligned. Codes 5, 6 and 7 are unused: they never raise `frame_valid`, and the outputs stay at zero.
- R2: In the right-aligned formats, the sample is the last N data bits sampled before a word-select transition. Earlier bits in that half-frame are ignored. Word select high marks the left channel.
- R3: In the 20-bit left-aligned format, the MSB is the bit sampled on the first bit-clock rising edge after the word-select transition. The next 19 bits follow it. Word select high marks the left channel.
- R4: In the I2S-style format, the MSB is sampled on the second bit-clock rising edge after the word-select transition. Word select low marks the left channel. The word is 20 bits long when a half-frame has more than 16 bit clocks.
- R5: In the I2S-style format with exactly 16 bit clocks per half-frame (32 per frame), the word is 16 bits long. Its LSB is sampled on the first rising edge after the next word-select transition.
- R6: Every word is sign-extended from its own length to 24 bits on `left_out` and `right_out`.
- R7: `frame_valid` is high for exactly one system-clock cycle after each right-channel word that follows a left-channel word. `left_out` and `right_out` change only in a cycle where `frame_valid` is high.
- R8: `fmt_sel` is loaded only while `pwr_dn` is high. A change to `fmt_sel` while `pwr_dn` is low has no effect. While `pwr_dn` is high, the outputs are zero and `frame_valid` is low.
- R9: The number of bit clocks per half-frame may vary between configurations. A right-aligned word is still located correctly at 16, 24 or 32 bit clocks per half-frame.
- R10: Data and word select are sampled on bit-clock rising edges. The sender changes them after falling edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_dn | input | 1 | Power-down: clears receive state and loads the format code |
| fmt_sel | input | 3 | Format code, loaded only while pwr_dn is high |
| sck | input | 1 | Serial bit clock from the external master |
| ws | input | 1 | Word-select (left/right) clock from the external master |
| sd | input | 1 | Serial data, MSB first |
| left_out | output | 24 | Last complete left sample, sign-extended |
| right_out | output | 24 | Last complete right sample, sign-extended |
| frame_valid | output | 1 | One-cycle pulse when a new left/right pair is presented |

## Verification
The assertions assume that each bit-clock phase lasts at least a few system-clock cycles. With that spacing, synchronized rising edges are never adjacent and one captured word cannot follow another within a cycle. They also assume that the format code does not change in the cycle that `pwr_dn` falls. The stimulus keeps each bit-clock phase at four system cycles. It changes word select and data only while the bit clock is low. It sets `fmt_sel` before releasing power-down, except in the one test that changes the code mid-run on purpose.

// File: rtl/arx_pkg.sv
// Package: shared format codes, alignment kinds and the format decoder
// for the serial audio receiver. Assumes a 3-bit format code.
package arx_pkg;

    localparam logic [2:0] FMT_RJ16 = 3'd0;
    localparam logic [2:0] FMT_RJ20 = 3'd1;
    localparam logic [2:0] FMT_LJ20 = 3'd2;
    localparam logic [2:0] FMT_DLY  = 3'd3;
    localparam logic [2:0] FMT_RJ24 = 3'd4;

    typedef enum logic [1:0] {
        ALIGN_NONE,   // unused code: no capture
        ALIGN_RIGHT,  // word ends at the word-select transition
        ALIGN_LEFT,   // word starts at the word-select transition
        ALIGN_DELAY   // word starts one bit clock after the transition
    } arx_align_e;

    typedef struct packed {
        arx_align_e align;
        logic [4:0] len;   // word length in bits
    } arx_cfg_t;

    // Translate the latched format code into alignment and word length.
    function automatic arx_cfg_t decode_fmt(input logic [2:0] code);
        arx_cfg_t c;
        case (code)
            FMT_RJ16: c = '{align: ALIGN_RIGHT, len: 5'd16};
            FMT_RJ20: c = '{align: ALIGN_RIGHT, len: 5'd20};
            FMT_LJ20: c = '{align: ALIGN_LEFT,  len: 5'd20};
            FMT_DLY:  c = '{align: ALIGN_DELAY, len: 5'd20};
            FMT_RJ24: c = '{align: ALIGN_RIGHT, len: 5'd24};
            default:  c = '{align: ALIGN_NONE,  len: 5'd16};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/arx_sync.sv
// Module: arx_sync
// Brings the three serial lines into the system-clock domain and flags
// bit-clock rising edges. All lines pass through the same number of
// stages, so ws_s and sd_s line up with sck_rise.
// Assumes each bit-clock phase lasts longer than one system-clock cycle.
module arx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic sck,
    input  logic ws,
    input  logic sd,
    output logic sck_rise,
    output logic ws_s,
    output logic sd_s
);
    logic [STAGES-1:0] sck_p, ws_p, sd_p;
    logic              sck_last;

    // Shift the serial lines through the synchronizer chains.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sck_p    <= '0;
            ws_p     <= '0;
            sd_p     <= '0;
            sck_last <= 1'b0;
        end else begin
            sck_p    <= {sck_p[STAGES-2:0], sck};
            ws_p     <= {ws_p[STAGES-2:0], ws};
            sd_p     <= {sd_p[STAGES-2:0], sd};
            sck_last <= sck_p[STAGES-1];
        end
    end

    assign sck_rise = sck_p[STAGES-1] & ~sck_last;
    assign ws_s     = ws_p[STAGES-1];
    assign sd_s     = sd_p[STAGES-1];
endmodule

// File: rtl/arx_deser.sv
// Module: arx_deser
// Shifts in one data bit per bit-clock rising edge, tracks the half-frame
// boundary and captures words according to the decoded format. The
// delayed format is handled by using the word select of the previous bit
// clock as the effective boundary. Captured words are sign-extended.
// Assumes cfg is held while clr is low.
module arx_deser
    import arx_pkg::*;
#(
    parameter int OUT_W = 24,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  arx_cfg_t         cfg,
    input  logic             sck_rise,
    input  logic             ws_s,
    input  logic             sd_s,
    output logic             cap_valid,
    output logic             cap_left,
    output logic [OUT_W-1:0] cap_data
);
    localparam logic [CNT_W-1:0] SHORT_HALF = CNT_W'(16);

    logic [OUT_W-1:0] shreg, shifted, raw;
    logic [CNT_W-1:0] cnt, cnt_next;
    logic [1:0]       hist;
    logic             ch_ws, ws_last, armed;
    logic             eff_ws, eff_edge, is_dly, edge_cap, mid_cap, half_left;
    logic [4:0]       len;

    // Sign-extend the low len bits of raw to the full output width.
    function automatic logic [OUT_W-1:0] sext(input logic [OUT_W-1:0] r,
                                              input logic [4:0] n);
        logic [OUT_W-1:0] o;
        for (int i = 0; i < OUT_W; i++)
            o[i] = (i < int'(n)) ? r[i] : r[n - 5'd1];
        return o;
    endfunction

    // Boundary detection, bit counting and capture decision.
    always_comb begin
        is_dly    = (cfg.align == ALIGN_DELAY);
        eff_ws    = is_dly ? ws_last : ws_s;
        eff_edge  = (hist == 2'd2) && (eff_ws != ch_ws);
        cnt_next  = eff_edge ? CNT_W'(1) : ((&cnt) ? cnt : cnt + CNT_W'(1));
        shifted   = {shreg[OUT_W-2:0], sd_s};
        edge_cap  = eff_edge && armed &&
                    ((cfg.align == ALIGN_RIGHT) || (is_dly && cnt == SHORT_HALF));
        mid_cap   = !eff_edge && armed &&
                    ((cfg.align == ALIGN_LEFT) || is_dly) &&
                    (cnt_next == CNT_W'(cfg.len));
        raw       = edge_cap ? shreg : shifted;
        len       = (edge_cap && is_dly) ? 5'd16 : cfg.len;
        half_left = is_dly ? ~ch_ws : ch_ws;
    end

    // Update serial state on each bit-clock rising edge and emit captures.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            shreg     <= '0;
            cnt       <= '0;
            hist      <= 2'd0;
            ch_ws     <= 1'b0;
            ws_last   <= 1'b0;
            armed     <= 1'b0;
            cap_valid <= 1'b0;
            cap_left  <= 1'b0;
            cap_data  <= '0;
        end else begin
            cap_valid <= 1'b0;
            if (sck_rise) begin
                shreg   <= shifted;
                cnt     <= cnt_next;
                ch_ws   <= eff_ws;
                ws_last <= ws_s;
                if (hist != 2'd2) hist <= hist + 2'd1;
                if (eff_edge) armed <= 1'b1;
                if (edge_cap || mid_cap) begin
                    cap_valid <= 1'b1;
                    cap_left  <= half_left;
                    cap_data  <= sext(raw, len);
                end
            end
        end
    end
endmodule

// File: rtl/arx_frame_out.sv
// Module: arx_frame_out
// Holds a captured left word until the matching right word arrives.
// Then it updates both outputs together and pulses frame_valid.
// Assumes captures arrive at least two cycles apart.
module arx_frame_out #(
    parameter int OUT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             cap_valid,
    input  logic             cap_left,
    input  logic [OUT_W-1:0] cap_data,
    output logic [OUT_W-1:0] left_out,
    output logic [OUT_W-1:0] right_out,
    output logic             frame_valid
);
    logic [OUT_W-1:0] left_hold;
    logic             left_ok;

    // Pair left and right words and publish them as one frame.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            left_hold   <= '0;
            left_ok     <= 1'b0;
            left_out    <= '0;
            right_out   <= '0;
            frame_valid <= 1'b0;
        end else begin
            frame_valid <= 1'b0;
            if (cap_valid && cap_left) begin
                left_hold <= cap_data;
                left_ok   <= 1'b1;
            end else if (cap_valid && left_ok) begin
                left_out    <= left_hold;
                right_out   <= cap_data;
                frame_valid <= 1'b1;
                left_ok     <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/audio_rx_slave.sv
// Module: audio_rx_slave (top)
// Slave-only multi-format serial audio receiver. It latches the format
// code during power-down and chains the synchronizer, the deserializer
// and the frame output stage.
// Assumes sck is much slower than clk; OUT_W must be at least 24.
module audio_rx_slave
    import arx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int OUT_W       = 24,
    parameter int CNT_W       = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_dn,
    input  logic [2:0]       fmt_sel,
    input  logic             sck,
    input  logic             ws,
    input  logic             sd,
    output logic [OUT_W-1:0] left_out,
    output logic [OUT_W-1:0] right_out,
    output logic             frame_valid
);
    logic [2:0]       fmt_q;
    arx_cfg_t         cfg;
    logic             sck_rise, ws_s, sd_s;
    logic             cap_valid, cap_left;
    logic [OUT_W-1:0] cap_data;

    // Load the format code only while powered down.
    always_ff @(posedge clk) begin
        if (!rst_n)      fmt_q <= 3'd0;
        else if (pwr_dn) fmt_q <= fmt_sel;
    end

    assign cfg = decode_fmt(fmt_q);

    arx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .clr(pwr_dn),
        .sck(sck), .ws(ws), .sd(sd),
        .sck_rise(sck_rise), .ws_s(ws_s), .sd_s(sd_s)
    );

    arx_deser #(.OUT_W(OUT_W), .CNT_W(CNT_W)) u_deser (
        .clk(clk), .rst_n(rst_n), .clr(pwr_dn), .cfg(cfg),
        .sck_rise(sck_rise), .ws_s(ws_s), .sd_s(sd_s),
        .cap_valid(cap_valid), .cap_left(cap_left), .cap_data(cap_data)
    );

    arx_frame_out #(.OUT_W(OUT_W)) u_out (
        .clk(clk), .rst_n(rst_n), .clr(pwr_dn),
        .cap_valid(cap_valid), .cap_left(cap_left), .cap_data(cap_data),
        .left_out(left_out), .right_out(right_out), .frame_valid(frame_valid)
    );
endmodule

// File: rtl/arx_checker.sv
// Module: arx_checker
// Temporal properties of the receiver's output side, bound to the top.
module arx_checker #(
    parameter int OUT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwr_dn,
    input logic [2:0]       fmt_q,
    input logic [OUT_W-1:0] left_out,
    input logic [OUT_W-1:0] right_out,
    input logic             frame_valid
);
    // R7
    valid_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid);

    // R7
    outputs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_valid && !pwr_dn) |-> ($stable(left_out) && $stable(right_out)));

    // R8
    powerdown_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> (!frame_valid && left_out == '0 && right_out == '0));

    // R8
    fmt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_dn |=> $stable(fmt_q));

    // R1
    unused_code_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_q >= 3'd5) |-> !frame_valid);

    // R6
    sign_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && fmt_q != 3'd4) |->
            ((left_out[OUT_W-1:19] == '0 || left_out[OUT_W-1:19] == '1) &&
             (right_out[OUT_W-1:19] == '0 || right_out[OUT_W-1:19] == '1)));
endmodule

bind audio_rx_slave arx_checker #(.OUT_W(OUT_W)) u_arx_chk (
    .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .fmt_q(fmt_q),
    .left_out(left_out), .right_out(right_out), .frame_valid(frame_valid)
);

// File: tb/tb_audio_rx_slave.sv
// Directed bench for audio_rx_slave: one task per scenario.
module tb_audio_rx_slave;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_dn = 1'b1;
    logic [2:0]  fmt_sel = 3'd0;
    logic        sck = 1'b0, ws = 1'b0, sd = 1'b0;
    logic [23:0] left_out, right_out;
    logic        frame_valid;

    int checks = 0, errors = 0;
    int vcount = 0, width_err = 0, stab_err = 0;
    logic [23:0] got_l = '0, got_r = '0, last_l = '0, last_r = '0;
    logic        prev_v = 1'b0, mon_on = 1'b0;
    bit          done = 1'b0;

    // stream shape: 0 right-aligned, 1 left-aligned, 2 delayed
    int          cur_mode, cur_h, cur_n;
    logic [23:0] cur_l, cur_r;

    audio_rx_slave dut (
        .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .fmt_sel(fmt_sel),
        .sck(sck), .ws(ws), .sd(sd),
        .left_out(left_out), .right_out(right_out), .frame_valid(frame_valid)
    );

    always #5 clk = ~clk;

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (mon_on) begin
            if (frame_valid) begin
                vcount++;
                got_l = left_out;
                got_r = right_out;
                if (prev_v) width_err++;
            end else if (left_out !== last_l || right_out !== last_r) begin
                stab_err++;
            end
        end
        prev_v = frame_valid;
        last_l = left_out;
        last_r = right_out;
    end

    task automatic chk(input bit ok, input string req, input logic [23:0] act,
                       input logic [23:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] bsext(input logic [23:0] w, input int n);
        logic [23:0] o;
        for (int i = 0; i < 24; i++) o[i] = (i < n) ? w[i] : w[n-1];
        return o;
    endfunction

    function automatic logic left_word_bit(input int g);
        int p = g % cur_h;
        logic [23:0] w = (g < cur_h) ? cur_l : cur_r;
        return (p < cur_n) ? w[cur_n-1-p] : g[0];
    endfunction

    function automatic logic sd_at(input int g);
        int p = g % cur_h;
        logic [23:0] w = (g < cur_h) ? cur_l : cur_r;
        if (cur_mode == 0) return (p >= cur_h - cur_n) ? w[cur_h-1-p] : g[0];
        if (cur_mode == 1) return left_word_bit(g);
        return left_word_bit((g + 2*cur_h - 1) % (2*cur_h));
    endfunction

    function automatic logic ws_at(input int g);
        logic lft = (g < cur_h);
        return (cur_mode == 2) ? ~lft : lft;
    endfunction

    // Drive frames: data and word select change while sck is low.
    task automatic send_frames(input int count);
        for (int f = 0; f < count; f++)
            for (int g = 0; g < 2*cur_h; g++) begin
                @(negedge clk) begin sck = 1'b0; ws = ws_at(g); sd = sd_at(g); end
                repeat (3) @(negedge clk);
                @(negedge clk) sck = 1'b1;
                repeat (3) @(negedge clk);
            end
    endtask

    task automatic power_cycle(input logic [2:0] code);
        @(negedge clk) begin pwr_dn = 1'b1; fmt_sel = code; sck = 1'b0; end
        repeat (4) @(negedge clk);
        @(negedge clk) pwr_dn = 1'b0;
        @(negedge clk);
        vcount = 0; width_err = 0; stab_err = 0; got_l = '0; got_r = '0;
        mon_on = 1'b1;
    endtask

    // Generic scenario: load code, optionally alter fmt_sel after release.
    task automatic run_case(input string req, input logic [2:0] code,
                            input logic [2:0] code_after, input int mode,
                            input int h, input int n,
                            input logic [23:0] l, input logic [23:0] r);
        cur_mode = mode; cur_h = h; cur_n = n; cur_l = l; cur_r = r;
        power_cycle(code);
        fmt_sel = code_after;
        send_frames(4);
        repeat (10) @(negedge clk);
        mon_on = 1'b0;
        chk(vcount >= 2, {req, " frame count"}, 24'(vcount), 24'd2);
        chk(got_l === bsext(l, n), {req, " left"}, got_l, bsext(l, n));
        chk(got_r === bsext(r, n), {req, " right"}, got_r, bsext(r, n));
        chk(width_err == 0 && stab_err == 0, {req, " R7 pulse/hold"},
            24'(width_err + stab_err), 24'd0);
    endtask

    task automatic test_reset();
        repeat (3) @(negedge clk);
        chk(left_out === '0 && right_out === '0, "R8 reset outputs",
            left_out | right_out, 24'd0);
        chk(frame_valid === 1'b0, "R7 reset valid", 24'(frame_valid), 24'd0);
    endtask

    task automatic test_unused();
        cur_mode = 1; cur_h = 32; cur_n = 20; cur_l = 24'h4_5678; cur_r = 24'h9_ABCD;
        power_cycle(3'd6);
        send_frames(4);
        repeat (10) @(negedge clk);
        mon_on = 1'b0;
        chk(vcount == 0, "R1 unused code no valid", 24'(vcount), 24'd0);
        chk(left_out === '0 && right_out === '0, "R1 unused code outputs",
            left_out | right_out, 24'd0);
    endtask

    task automatic test_powerdown_clear();
        @(negedge clk) pwr_dn = 1'b1;
        repeat (3) @(negedge clk);
        chk(left_out === '0 && right_out === '0 && !frame_valid,
            "R8 power-down clears", left_out | right_out, 24'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        run_case("R2 R6 16-bit right", 3'd0, 3'd0, 0, 32, 16, 24'h1234, 24'hFFFB);
        run_case("R9 R10 16-bit right 16 clocks", 3'd0, 3'd0, 0, 16, 16, 24'h8001, 24'h7FFF);
        run_case("R2 20-bit right", 3'd1, 3'd1, 0, 32, 20, 24'h8_1234, 24'h7_ABCD);
        run_case("R9 R6 24-bit right 24 clocks", 3'd4, 3'd4, 0, 24, 24, 24'h80_0001, 24'h12_3456);
        run_case("R3 left-aligned 32 clocks", 3'd2, 3'd2, 1, 32, 20, 24'hF_0F0F, 24'h0_1234);
        run_case("R3 left-aligned 20 clocks", 3'd2, 3'd2, 1, 20, 20, 24'h5_A5A5, 24'hA_5A5A);
        run_case("R4 delayed 32 clocks", 3'd3, 3'd3, 2, 32, 20, 24'h9_8765, 24'h1_2345);
        run_case("R4 delayed 20 clocks", 3'd3, 3'd3, 2, 20, 20, 24'h7_FFFF, 24'h8_0000);
        run_case("R5 delayed 16-bit", 3'd3, 3'd3, 2, 16, 16, 24'hC3A5, 24'h3C5A);
        run_case("R8 fmt change ignored", 3'd2, 3'd0, 1, 32, 20, 24'h6_1357, 24'hE_2468);
        test_powerdown_clear();
        test_unused();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule